// File: doc/BRIEF.md
# DAC Bring-Up Sequencer

This block sits on the host side of a 20-bit serial DAC. It brings the converter out of its power-on state with a fixed script and then confirms that the link works. When `start` is pulsed while the block is idle, it drives six 24-bit frames in turn over a three-wire serial link that it masters. Every frame has one read/write flag, three address bits and twenty data bits, and it is sent most significant bit first. The six frames are: a configuration word, a mid-scale code write, a full-scale clear value write, a software clear command, a request to read the clear value, and a trailing no-op frame. The DAC shifts the requested contents out during that last frame.

At the end of the script the sequencer compares the captured readback with the full-scale value it programmed. It then raises `done`, together with `error` if the two differ. Both flags stay up until the next start. The serial clock is derived from the system clock by an even division factor. The frame-sync line stays high for a parameterised number of serial clock periods between frames.

Top module: `dac_bringup_seq`

## Requirements
- R1: While `rst` is high and after it is released, `sync_n` is 1 and `sclk`, `sdin`, `busy`, `done` and `error` are 0.
- R2: A `start` pulse seen while `busy` is 0 sets `busy` and sends exactly six frames, MSB first, in this order: 0x200012, 0x180000, 0x3FFFFF, 0x400002, 0xB00000, 0x000000. In these words bit 23 is read/write (1 = read), bits 22:20 are the address and bits 19:0 are the data.
- R3: `sclk` rests low, is low whenever `sync_n` is high, and has a period of `CLK_DIV` system clocks with a high phase of `CLK_DIV/2` clocks inside a frame.
- R4: `sdin` changes only on a cycle in which `sclk` rises. The DAC samples `sdin` on the falling edge, and the block samples `sdo` on the falling edge.
- R5: Between two frames of a run, `sync_n` stays high for at least `GAP_SCLK*CLK_DIV` system clocks.
- R6: The bits received on `sdo` during the final no-op frame are the readback. `error` is raised at the end of the run if their low 20 bits differ from 0xFFFFF, and stays 0 if they match.
- R7: After the last frame, `busy` falls and `done` rises. `done` and `error` hold their values until the next accepted `start`, which clears both.
- R8: A `start` pulse seen while `busy` is 1 has no effect: the run continues unchanged and still sends exactly six frames.
- R9: Asserting `rst` during a run stops it at once: `sync_n` returns high, `sclk` goes low and `busy` goes low. A later `start` runs the full script again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that launches the bring-up script when idle |
| sdo | input | 1 | Serial data returned by the DAC |
| sclk | output | 1 | Serial clock to the DAC |
| sdin | output | 1 | Serial data to the DAC |
| sync_n | output | 1 | Frame sync, low during a frame |
| busy | output | 1 | High while the script runs |
| done | output | 1 | High once the script has finished, until the next start |
| error | output | 1 | High with `done` when the readback did not match |

## Verification
The bench builds the sequencer with `CLK_DIV = 4` and `GAP_SCLK = 2`. This gives a two-cycle high phase, so a half-period slip of one system clock changes the measured edge spacing visibly. A full six-frame run stays near seven hundred cycles, which leaves room for three runs, a mid-run reset and a corrupted readback. The behavioural DAC model in the bench answers the read request with a bit flip that can be switched on. The comparison path is therefore exercised in both its matching and its mismatching outcome.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

   localparam int DAC_DATA_W  = 20;
   localparam int DAC_ADDR_W  = 3;
   localparam int DAC_FRAME_W = DAC_DATA_W + DAC_ADDR_W + 1;

   typedef logic [DAC_ADDR_W-1:0] dac_addr_t;
   typedef logic [DAC_DATA_W-1:0] dac_data_t;
   typedef logic [DAC_FRAME_W-1:0] dac_frame_t;

   localparam dac_addr_t ADDR_NOP    = 3'd0;
   localparam dac_addr_t ADDR_CODE   = 3'd1;
   localparam dac_addr_t ADDR_CFG    = 3'd2;
   localparam dac_addr_t ADDR_CLRVAL = 3'd3;
   localparam dac_addr_t ADDR_SWCMD  = 3'd4;

   // configuration fields: amplifier off (bit 1), offset binary (bit 4);
   // tristate, ground clamp, output disable and linearity span left at 0
   localparam int CFG_AMP_OFF_BIT    = 1;
   localparam int CFG_OFFSET_BIN_BIT = 4;
   localparam int SWCMD_CLEAR_BIT    = 1;

   localparam dac_data_t CODE_FULL = '1;
   localparam dac_data_t CODE_MID  = dac_data_t'(1) << (DAC_DATA_W - 1);
   localparam dac_data_t CFG_WORD  = (dac_data_t'(1) << CFG_AMP_OFF_BIT)
                                   | (dac_data_t'(1) << CFG_OFFSET_BIN_BIT);
   localparam dac_data_t SWCMD_CLR = dac_data_t'(1) << SWCMD_CLEAR_BIT;

   typedef enum logic [2:0] {
      STEP_CFG,
      STEP_MID,
      STEP_CLRVAL,
      STEP_SWCLR,
      STEP_RDREQ,
      STEP_COLLECT
   } seq_step_e;

   localparam seq_step_e STEP_LAST = STEP_COLLECT;

   function automatic dac_frame_t pack_frame(input logic rd, input dac_addr_t addr,
                                             input dac_data_t data);
      return {rd, addr, data};
   endfunction

   function automatic dac_frame_t frame_for(input seq_step_e step);
      case (step)
         STEP_CFG:     return pack_frame(1'b0, ADDR_CFG,    CFG_WORD);
         STEP_MID:     return pack_frame(1'b0, ADDR_CODE,   CODE_MID);
         STEP_CLRVAL:  return pack_frame(1'b0, ADDR_CLRVAL, CODE_FULL);
         STEP_SWCLR:   return pack_frame(1'b0, ADDR_SWCMD,  SWCMD_CLR);
         STEP_RDREQ:   return pack_frame(1'b1, ADDR_CLRVAL, '0);
         default:      return pack_frame(1'b0, ADDR_NOP,    '0);
      endcase
   endfunction

endpackage

// File: rtl/dac_sclk_timer.sv
module dac_sclk_timer #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   output logic tick
);

   generate
      if (HALF_DIV == 1) begin : g_direct
         assign tick = en;
      end else begin : g_count
         localparam int CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (rst || !en) begin
               cnt <= '0;
            end else if (cnt == CNT_LAST) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end

         assign tick = en && (cnt == CNT_LAST);
      end
   endgenerate

endmodule

// File: rtl/dac_frame_engine.sv
module dac_frame_engine #(
   parameter int FRAME_W  = 24,
   parameter int KEEP_W   = 20,
   parameter int HALF_DIV = 2,
   parameter int GAP_SCLK = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               launch,
   input  logic [FRAME_W-1:0] tx_word,
   input  logic               sdo,
   output logic               sclk,
   output logic               sdin,
   output logic               sync_n,
   output logic [KEEP_W-1:0]  rx_word,
   output logic               frame_done
);

   localparam int SHIFT_TICKS = 2 * FRAME_W;
   localparam int TOTAL_TICKS = SHIFT_TICKS + 2 * GAP_SCLK;
   localparam int TW          = $clog2(TOTAL_TICKS + 1);
   localparam logic [TW-1:0] IDX_SHIFT_END = TW'(SHIFT_TICKS);
   localparam logic [TW-1:0] IDX_LAST_FALL = TW'(SHIFT_TICKS - 1);
   localparam logic [TW-1:0] IDX_END       = TW'(TOTAL_TICKS - 1);

   logic               active;
   logic               tick;
   logic [TW-1:0]      idx;
   logic [FRAME_W-1:0] tx_reg;

   dac_sclk_timer #(.HALF_DIV(HALF_DIV)) u_timer (
      .clk  (clk),
      .rst  (rst),
      .en   (active),
      .tick (tick)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         active     <= 1'b0;
         sync_n     <= 1'b1;
         sclk       <= 1'b0;
         sdin       <= 1'b0;
         idx        <= '0;
         tx_reg     <= '0;
         rx_word    <= '0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         if (launch && !active) begin
            active <= 1'b1;
            sync_n <= 1'b0;
            idx    <= '0;
            tx_reg <= tx_word;
         end else if (active && tick) begin
            idx <= idx + 1'b1;
            if (idx < IDX_SHIFT_END) begin
               if (!idx[0]) begin
                  sclk   <= 1'b1;
                  sdin   <= tx_reg[FRAME_W-1];
                  tx_reg <= tx_reg << 1;
               end else begin
                  sclk    <= 1'b0;
                  rx_word <= {rx_word[KEEP_W-2:0], sdo};
                  if (idx == IDX_LAST_FALL) begin
                     sync_n <= 1'b1;
                  end
               end
            end
            if (idx == IDX_END) begin
               active     <= 1'b0;
               frame_done <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/dac_bringup_seq.sv
module dac_bringup_seq #(
   parameter int CLK_DIV  = 4,
   parameter int GAP_SCLK = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic sdo,
   output logic sclk,
   output logic sdin,
   output logic sync_n,
   output logic busy,
   output logic done,
   output logic error
);

   import dac_seq_pkg::*;

   localparam int HALF_DIV = CLK_DIV / 2;

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (GAP_SCLK < 2) begin : g_bad_gap
         $error("GAP_SCLK must be at least 2");
      end
   endgenerate

   seq_step_e  step;
   logic       launch;
   logic       frame_done;
   dac_data_t  rx_word;
   dac_frame_t tx_word;

   assign tx_word = frame_for(step);

   dac_frame_engine #(
      .FRAME_W  (DAC_FRAME_W),
      .KEEP_W   (DAC_DATA_W),
      .HALF_DIV (HALF_DIV),
      .GAP_SCLK (GAP_SCLK)
   ) u_engine (
      .clk        (clk),
      .rst        (rst),
      .launch     (launch),
      .tx_word    (tx_word),
      .sdo        (sdo),
      .sclk       (sclk),
      .sdin       (sdin),
      .sync_n     (sync_n),
      .rx_word    (rx_word),
      .frame_done (frame_done)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         step   <= STEP_CFG;
         launch <= 1'b0;
         busy   <= 1'b0;
         done   <= 1'b0;
         error  <= 1'b0;
      end else begin
         launch <= 1'b0;
         if (!busy && start) begin
            busy   <= 1'b1;
            done   <= 1'b0;
            error  <= 1'b0;
            step   <= STEP_CFG;
            launch <= 1'b1;
         end else if (busy && frame_done) begin
            if (step == STEP_LAST) begin
               busy  <= 1'b0;
               done  <= 1'b1;
               error <= (rx_word != CODE_FULL);
            end else begin
               step   <= seq_step_e'(step + 3'd1);
               launch <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/dac_bringup_seq_chk.sv
module dac_bringup_seq_chk (
   input logic clk,
   input logic rst,
   input logic sclk,
   input logic sdin,
   input logic sync_n,
   input logic busy,
   input logic done,
   input logic error
);

   // R1 R9
   sync_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !busy |-> sync_n);

   // R3
   sclk_park_chk: assert property (@(posedge clk) disable iff (rst)
      sync_n |-> !sclk);

   // R4
   sdin_edge_chk: assert property (@(posedge clk) disable iff (rst)
      !$rose(sclk) |-> $stable(sdin));

   // R7
   done_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(done && busy));

   // R6
   error_with_done_chk: assert property (@(posedge clk) disable iff (rst)
      error |-> done);

   // R6 R7
   error_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(error) |-> $rose(done));

endmodule

bind dac_bringup_seq dac_bringup_seq_chk u_chk (
   .clk    (clk),
   .rst    (rst),
   .sclk   (sclk),
   .sdin   (sdin),
   .sync_n (sync_n),
   .busy   (busy),
   .done   (done),
   .error  (error)
);

// File: tb/dac_bringup_seq_bench.sv
module dac_bringup_seq_bench;

   localparam int DIV = 4;
   localparam int GAP = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic sdo = 1'b0;
   logic sclk, sdin, sync_n, busy, done, error;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   dac_bringup_seq #(.CLK_DIV(DIV), .GAP_SCLK(GAP)) u_dac_bringup_seq (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .sdo    (sdo),
      .sclk   (sclk),
      .sdin   (sdin),
      .sync_n (sync_n),
      .busy   (busy),
      .done   (done),
      .error  (error)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural DAC slave and per-clock protocol model
   logic [23:0] frames[$];
   logic [23:0] shift_in, resp;
   logic [19:0] clear_val = '0;
   logic [19:0] corrupt = '0;
   int bitcnt, gap_cnt, cyc, last_rise;
   bit pending_read, gap_armed, rise_valid;
   logic p_sclk = 1'b0, p_sync = 1'b1, p_sdin = 1'b0, p_rst = 1'b1;

   always @(negedge clk) begin
      cyc++;
      if (rst) begin
         pending_read = 0;
         gap_armed    = 0;
         rise_valid   = 0;
         sdo          = 1'b0;
      end else begin
         if (!p_rst) begin
            // R2 R9: sync stays high when idle
            check(busy || sync_n, "R2 sync low while idle", {31'd0, sync_n}, 32'd1);
            // R3: clock parked while sync high
            check(!sync_n || !sclk, "R3 sclk high with sync high", {31'd0, sclk}, 32'd0);
            // R4: data moves only with a rising clock
            check((sclk && !p_sclk) || (sdin == p_sdin), "R4 sdin moved off rising edge",
                  {31'd0, sdin}, {31'd0, p_sdin});
         end
         if (!busy && !(sync_n && !p_sync)) gap_armed = 0;
         if (!sync_n && p_sync) begin
            if (gap_armed)
               check(gap_cnt >= GAP * DIV, "R5 gap", gap_cnt, GAP * DIV);
            gap_armed  = 0;
            shift_in   = '0;
            bitcnt     = 0;
            rise_valid = 0;
            resp = pending_read ? {4'hB, clear_val ^ corrupt} : 24'd0;
         end
         if (sclk && !p_sclk && !sync_n) begin
            if (rise_valid)
               check(cyc - last_rise == DIV, "R3 period", cyc - last_rise, DIV);
            rise_valid = 1;
            last_rise  = cyc;
            sdo  = resp[23];
            resp = {resp[22:0], 1'b0};
         end
         if (!sclk && p_sclk && !p_sync) begin
            check(cyc - last_rise == DIV / 2, "R3 high phase", cyc - last_rise, DIV / 2);
            shift_in = {shift_in[22:0], sdin};
            bitcnt++;
         end
         if (sync_n && !p_sync) begin
            if (bitcnt == 24) begin
               frames.push_back(shift_in);
               pending_read = shift_in[23];
               if (!shift_in[23] && shift_in[22:20] == 3'd3) clear_val = shift_in[19:0];
               gap_armed = 1;
               gap_cnt   = 0;
            end else begin
               pending_read = 0;
            end
         end else if (sync_n && gap_armed) begin
            gap_cnt++;
         end
      end
      p_sclk = sclk;
      p_sync = sync_n;
      p_sdin = sdin;
      p_rst  = rst;
   end

   logic [23:0] exp_frames [6];
   initial begin
      exp_frames[0] = 24'h200012;
      exp_frames[1] = 24'h180000;
      exp_frames[2] = 24'h3FFFFF;
      exp_frames[3] = 24'h400002;
      exp_frames[4] = 24'hB00000;
      exp_frames[5] = 24'h000000;
   end

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      int n = 0;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
      end
      check(done, tag, {31'd0, done}, 32'd1);
   endtask

   task automatic check_frames(input string tag);
      check(frames.size() == 6, tag, frames.size(), 6);
      for (int i = 0; i < 6 && i < frames.size(); i++)
         check(frames[i] == exp_frames[i], tag, frames[i], exp_frames[i]);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check(sync_n && !sclk && !sdin, "R1 link idle", {29'd0, sync_n, sclk, sdin}, 32'h4);
      check(!busy && !done && !error, "R1 flags", {29'd0, busy, done, error}, 32'd0);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      check(sync_n && !busy, "R1 after release", {30'd0, sync_n, busy}, 32'h2);

      // run 1: good readback, extra start while busy (R8)
      frames.delete();
      pulse_start();
      check(busy, "R2 busy after start", {31'd0, busy}, 32'd1);
      repeat (100) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy && !done, "R8 start while busy", {30'd0, busy, done}, 32'h2);
      wait_done("R7 done after run 1");
      check(!busy, "R7 busy low at end", {31'd0, busy}, 32'd0);
      check(!error, "R6 matching readback", {31'd0, error}, 32'd0);
      check_frames("R2 R8 frame sequence run 1");
      repeat (50) @(negedge clk);
      check(done && !error && sync_n, "R7 flags held", {29'd0, done, error, sync_n}, 32'h5);

      // run 2: corrupted readback
      corrupt = 20'h00100;
      frames.delete();
      pulse_start();
      check(!done && busy, "R7 start clears done", {30'd0, done, busy}, 32'h1);
      wait_done("R7 done after run 2");
      check(error, "R6 mismatching readback", {31'd0, error}, 32'd1);
      check_frames("R2 frame sequence run 2");

      // run 3: reset mid-run, then full run
      corrupt = '0;
      pulse_start();
      repeat (300) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check(sync_n && !sclk && !busy, "R9 reset mid-run", {29'd0, sync_n, sclk, busy}, 32'h4);
      check(!done && !error, "R9 flags cleared", {30'd0, done, error}, 32'd0);
      rst = 1'b0;
      repeat (4) @(negedge clk);
      frames.delete();
      pulse_start();
      wait_done("R9 done after restart");
      check(!error, "R9 readback after restart", {31'd0, error}, 32'd0);
      check_frames("R9 frame sequence after restart");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule